// File: doc/BRIEF.md
# Trellis final-state agglomeration calculator

This block finds the state a recursive convolutional encoder reaches after a run of N hard input bits. It does not step the encoder N times. With m trellis states the feedback matrix returns to identity after m' = m − 1 steps. The block therefore folds the incoming bits into m' lanes: bit k is XORed into lane k mod m'. Once the sequence has ended, it runs the encoder m' times, feeding lane 0 first. If N is not a multiple of m', it then runs f = N mod m' further steps with zero input. The work after the last bit is m' + f state updates instead of N.

Bits arrive one per clock with a valid flag, and a last flag marks the final bit. A start pulse loads the start state and clears the lanes. If no start comes between two sequences, the next sequence continues from the previous final state. A parameter selects a 4-state code (m' = 3) or an 8-state code (m' = 7). The result appears on a registered output together with a one-cycle done strobe.

Top module: `tfs_agglom`

## Requirements
- R1: After reset, done is 0 and final_state is 0.
- R2: With CODE=0 the state is 2 bits. Bit 0 is s0 and bit 1 is s1. One step is s0' = s0^s1^d, s1' = s0. For N a multiple of 3, final_state equals N such steps from the start state over the input bits in arrival order.
- R3: For N not a multiple of m', final_state still equals the plain N-step encoder result. The block gets there through the m' lane steps and then N mod m' zero-input steps.
- R4: Suppose the last bit is accepted at clock edge T and f = N mod m'. Then done is high for exactly one cycle, following edge T + m' + f + 1. final_state changes only at that edge and holds afterwards.
- R5: While a computation is in progress, bit_valid, bit_last, bit_in, start and start_state have no effect on the result.
- R6: When the block is idle, start loads start_state and clears all lanes. A bit presented in the same cycle as start is discarded.
- R7: A sequence that follows a done strobe with no start in between begins from the previous final state.
- R8: With CODE=1 the state is 3 bits, with bits 0, 1 and 2 being s0, s1 and s2, and m' = 7. One step is s0' = d^s1^s2, s1' = s0, s2' = s1. final_state equals the N-step run of this step.
- R9: A one-bit sequence (N = 1) gives the single-step encoder result after m' + 1 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load start state and clear lanes (idle only) |
| start_state | input | SW | Encoder state at the start of the sequence |
| bit_valid | input | 1 | An input bit is present |
| bit_in | input | 1 | Input bit |
| bit_last | input | 1 | The bit present is the final one of the sequence |
| done | output | 1 | One-cycle strobe: final_state is new |
| final_state | output | SW | Encoder state after the sequence |

## Verification
The bench drives lengths that are exact multiples of m', lengths with every kind of remainder, and a single-bit run. Each result is compared with a plain step-by-step encoder. A block with a wrong lane order, a wrong modulo wrap or a missing or extra zero step would produce a different state, and a wrong step count also moves the done strobe off its expected cycle. Noise on every input during the computation exposes a block that keeps folding bits or reloads the state while busy. A start that shares its cycle with a bit would give a wrong state if that bit leaked into lane 0. A start-free second sequence would give a wrong state if the block reset its state register after done.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FOLD, ST_TAIL, ST_FIN} tfs_st_e;

  function automatic int lanes_of(int code);
    return (code == 1) ? 7 : 3;
  endfunction

  function automatic int width_of(int code);
    return (code == 1) ? 3 : 2;
  endfunction
endpackage

// File: rtl/tfs_step.sv
module tfs_step #(
  parameter int CODE = 0,
  parameter int SW   = 2
) (
  input  logic [SW-1:0] cur,
  input  logic          d,
  output logic [SW-1:0] nxt
);
  generate
    if (CODE == 1) begin : g_eight
      always_comb nxt = {cur[1], cur[0], d ^ cur[1] ^ cur[2]};
    end else begin : g_four
      always_comb nxt = {cur[0], d ^ cur[0] ^ cur[1]};
    end
  endgenerate
endmodule

// File: rtl/tfs_lane_accum.sv
module tfs_lane_accum #(
  parameter int MP = 3,
  parameter int PW = $clog2(MP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          accept,
  input  logic          bit_in,
  input  logic          hold,
  output logic [MP-1:0] lanes,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LAST_PH = PW'(MP - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lanes <= '0;
      phase <= '0;
    end else if (accept) begin
      lanes[phase] <= lanes[phase] ^ bit_in;
      phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
    end
  end

  // R3: lane index always stays inside the modulo range
  p_phase_range_r3: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PH);

  // R5: lanes frozen while the stepper is working
  p_hold_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (hold && !clr) |=> $stable(lanes));
endmodule

// File: rtl/tfs_stepper.sv
module tfs_stepper
  import tfs_pkg::*;
#(
  parameter int CODE = 0,
  parameter int MP   = 3,
  parameter int SW   = 2,
  parameter int PW   = $clog2(MP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] load_state,
  input  logic          go,
  input  logic [MP-1:0] lanes,
  input  logic [PW-1:0] phase,
  output logic          busy,
  output logic          clr,
  output logic          done,
  output logic [SW-1:0] final_state
);
  localparam logic [PW-1:0] LAST_CNT = PW'(MP - 1);

  tfs_st_e       st;
  logic [PW-1:0] cnt;
  logic [SW-1:0] cur;
  logic [SW-1:0] nxt;
  logic          d_in;

  always_comb d_in = (st == ST_FOLD) ? lanes[cnt] : 1'b0;

  tfs_step #(.CODE(CODE), .SW(SW)) u_step (
    .cur(cur),
    .d  (d_in),
    .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      cur         <= '0;
      done        <= 1'b0;
      final_state <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (load) begin
            cur <= load_state;
          end else if (go) begin
            st  <= ST_FOLD;
            cnt <= '0;
          end
        end
        ST_FOLD: begin
          cur <= nxt;
          if (cnt == LAST_CNT) begin
            cnt <= '0;
            st  <= (phase == '0) ? ST_FIN : ST_TAIL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          cur <= nxt;
          if (cnt == phase - 1'b1) begin
            cnt <= '0;
            st  <= ST_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          done        <= 1'b1;
          final_state <= cur;
          st          <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    busy = (st != ST_IDLE);
    clr  = (st == ST_FIN);
  end

  // R2: fold phase never indexes past the last lane
  p_fold_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FOLD) |-> (cnt <= LAST_CNT));

  // R3: zero-input steps only run for a nonzero remainder
  p_tail_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TAIL) |-> (phase != '0 && cnt < phase));

  // R4: done is a single-cycle strobe
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: done only follows the finishing state
  p_done_origin_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(st) == ST_FIN));
endmodule

// File: rtl/tfs_agglom.sv
module tfs_agglom #(
  parameter  int CODE = 0,
  localparam int SW   = tfs_pkg::width_of(CODE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] start_state,
  input  logic          bit_valid,
  input  logic          bit_in,
  input  logic          bit_last,
  output logic          done,
  output logic [SW-1:0] final_state
);
  localparam int MP = tfs_pkg::lanes_of(CODE);
  localparam int PW = $clog2(MP);

  logic          busy;
  logic          clr;
  logic          accept;
  logic          go;
  logic          load;
  logic          acc_clr;
  logic [MP-1:0] lanes;
  logic [PW-1:0] phase;

  always_comb begin
    load    = start & ~busy;
    accept  = bit_valid & ~busy & ~start;
    go      = accept & bit_last;
    acc_clr = clr | load;
  end

  tfs_lane_accum #(.MP(MP), .PW(PW)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .clr   (acc_clr),
    .accept(accept),
    .bit_in(bit_in),
    .hold  (busy),
    .lanes (lanes),
    .phase (phase)
  );

  tfs_stepper #(.CODE(CODE), .MP(MP), .SW(SW), .PW(PW)) u_stepper (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_state (start_state),
    .go         (go),
    .lanes      (lanes),
    .phase      (phase),
    .busy       (busy),
    .clr        (clr),
    .done       (done),
    .final_state(final_state)
  );
endmodule

// File: tb/tfs_agglom_bench.sv
`timescale 1ns/1ps
module tfs_agglom_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       a4_start = 0, a4_v = 0, a4_b = 0, a4_l = 0;
  logic [1:0] a4_x0 = 0;
  logic       a4_done;
  logic [1:0] a4_fs;
  logic       a8_start = 0, a8_v = 0, a8_b = 0, a8_l = 0;
  logic [2:0] a8_x0 = 0;
  logic       a8_done;
  logic [2:0] a8_fs;

  tfs_agglom #(.CODE(0)) u_tfs_agglom (
    .clk(clk), .rst(rst), .start(a4_start), .start_state(a4_x0),
    .bit_valid(a4_v), .bit_in(a4_b), .bit_last(a4_l),
    .done(a4_done), .final_state(a4_fs));

  tfs_agglom #(.CODE(1)) u_tfs_agglom_w8 (
    .clk(clk), .rst(rst), .start(a8_start), .start_state(a8_x0),
    .bit_valid(a8_v), .bit_in(a8_b), .bit_last(a8_l),
    .done(a8_done), .final_state(a8_fs));

  int total = 0;
  int fails = 0;
  logic [2:0] chain_st [2];
  logic [15:0] noise = 16'hACE1;

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(int code, logic st, logic [2:0] x0, logic v, logic b, logic l);
    if (code == 1) begin
      a8_start = st; a8_x0 = x0; a8_v = v; a8_b = b; a8_l = l;
    end else begin
      a4_start = st; a4_x0 = x0[1:0]; a4_v = v; a4_b = b; a4_l = l;
    end
  endtask

  function automatic logic [2:0] get_fs(int code);
    return (code == 1) ? a8_fs : {1'b0, a4_fs};
  endfunction

  function automatic logic get_done(int code);
    return (code == 1) ? a8_done : a4_done;
  endfunction

  function automatic logic [2:0] ref_step(int code, logic [2:0] s, logic d);
    if (code == 1) return {s[1], s[0], d ^ s[1] ^ s[2]};
    return {1'b0, s[0], d ^ s[0] ^ s[1]};
  endfunction

  task automatic next_noise();
    noise = {noise[14:0], noise[15] ^ noise[13] ^ noise[12] ^ noise[10]};
  endtask

  task automatic run_seq(int code, string tag, logic [2:0] x0, int n,
                         logic [15:0] seed, bit use_start, bit noisy, bit drop);
    logic [63:0] bits;
    logic [15:0] lf;
    logic [2:0]  exp;
    int mp, f, wait_n;
    mp = (code == 1) ? 7 : 3;
    f  = n % mp;
    wait_n = mp + f + 1;
    lf = seed;
    for (int i = 0; i < 64; i++) begin
      bits[i] = lf[0];
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end
    exp = use_start ? x0 : chain_st[code];
    if (code == 0) exp[2] = 1'b0;
    for (int i = 0; i < n; i++) exp = ref_step(code, exp, bits[i]);
    if (use_start) begin
      drive(code, 1'b1, x0, drop, drop, 1'b0);
      @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      drive(code, 1'b0, 3'd0, 1'b1, bits[i], (i == n - 1));
      @(negedge clk);
    end
    for (int k = 1; k <= wait_n; k++) begin
      if (noisy) begin
        next_noise();
        drive(code, noise[0], noise[3:1], noise[4], noise[5], noise[6]);
      end else begin
        drive(code, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      end
      @(negedge clk);
      if (k == wait_n) drive(code, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      check("R4 done timing", {2'b0, get_done(code)}, {2'b0, (k == wait_n)});
    end
    check(tag, get_fs(code), exp);
    chain_st[code] = exp;
    @(negedge clk);
    check("R4 done falls", {2'b0, get_done(code)}, 3'd0);
    check("R4 result held", get_fs(code), exp);
  endtask

  task automatic t_reset();
    check("R1 done 4-state", {2'b0, a4_done}, 3'd0);
    check("R1 state 4-state", {1'b0, a4_fs}, 3'd0);
    check("R1 done 8-state", {2'b0, a8_done}, 3'd0);
    check("R1 state 8-state", a8_fs, 3'd0);
  endtask

  task automatic t_fold_exact();
    run_seq(0, "R2 N=9", 3'd2, 9, 16'h1234, 1, 0, 0);
    run_seq(0, "R2 N=3", 3'd1, 3, 16'h0F0F, 1, 0, 0);
    run_seq(0, "R2 N=30", 3'd3, 30, 16'hBEEF, 1, 0, 0);
  endtask

  task automatic t_remainder();
    run_seq(0, "R3 N=10", 3'd3, 10, 16'h5A5A, 1, 0, 0);
    run_seq(0, "R3 N=11", 3'd0, 11, 16'hC0DE, 1, 0, 0);
    run_seq(1, "R3 N=17", 3'd6, 17, 16'h7777, 1, 0, 0);
    run_seq(1, "R3 N=64", 3'd1, 64, 16'h9A3C, 1, 0, 0);
  endtask

  task automatic t_single();
    run_seq(0, "R9 N=1 4-state", 3'd2, 1, 16'h0001, 1, 0, 0);
    run_seq(1, "R9 N=1 8-state", 3'd5, 1, 16'h0001, 1, 0, 0);
  endtask

  task automatic t_eight();
    run_seq(1, "R8 N=14", 3'd5, 14, 16'h4321, 1, 0, 0);
    run_seq(1, "R8 N=21", 3'd7, 21, 16'hFACE, 1, 0, 0);
    run_seq(1, "R8 N=13", 3'd0, 13, 16'h3C3C, 1, 0, 0);
  endtask

  task automatic t_busy();
    run_seq(0, "R5 noise 4-state", 3'd1, 8, 16'h2468, 1, 1, 0);
    run_seq(1, "R5 noise 8-state", 3'd3, 12, 16'h1357, 1, 1, 0);
  endtask

  task automatic t_start_drop();
    run_seq(0, "R6 start drops bit 4-state", 3'd2, 6, 16'h8421, 1, 0, 1);
    run_seq(1, "R6 start drops bit 8-state", 3'd4, 9, 16'h1248, 1, 0, 1);
  endtask

  task automatic t_chain();
    run_seq(0, "R7 chained 4-state", 3'd0, 5, 16'h6B6B, 0, 0, 0);
    run_seq(1, "R7 chained 8-state", 3'd0, 10, 16'hD00D, 0, 0, 0);
  endtask

  initial begin
    chain_st[0] = 3'd0;
    chain_st[1] = 3'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fold_exact();
    t_remainder();
    t_single();
    t_eight();
    t_busy();
    t_start_drop();
    t_chain();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule